// File: doc/BRIEF.md
# Clock and Reset Control Register Bank

This block is the software-visible control point for a chip's clock and reset controller. A 32-bit register port with a word address, a write strobe, write data and combinational read data reaches nine control words. These set which peripheral clocks run, the clock-source selection and division fields, two PLL configuration words, a power-management word, the wake-up source mask and wake-up flags, and the per-peripheral reset lines. The clock-enable and reset words drive the block's per-peripheral outputs. The select, divide, PLL and power words are presented unchanged to the clock-generation logic, which lies outside this block.

A second port reaches a set of small peripheral stub register files through a read-isolation stage. The stage shows what software sees from a peripheral that is gated or held in reset. A gated peripheral reads zero but keeps its contents. A peripheral held in reset is reloaded with its initial values and reads either all ones or all zeros, depending on its kind. Writes to a peripheral that is gated or held in reset are dropped.

Top module: `clkrst_regbank`

## Requirements
- R1: After the asynchronous reset, the clock-enable word (offset 0x00) reads 0xFFFFFFFF. Every other control word reads 0, and every stub register holds its initial value.
- R2: A write to a mapped offset updates only the implemented bits. The implemented bits are: clock enable 0x00, all 32 bits; select 0x04, mask 0x000007CF; divide 0x08, mask 0x3F0F0300; power 0x14, mask 0x0000000F; wake control 0x18, the low WAKE_N bits; reset lines 0x20, mask 0xF80DFFE9. Unimplemented bits read 0.
- R3: Offsets that map to no word, including 0x24 and every offset that is not word aligned, read 0, and writes to them change no register.
- R4: The PLL0 (0x0C) and PLL1 (0x10) words implement the input divider in bits 5:0, the output divider in 10:8, powerdown in bit 12, reset mode in bit 13 and the feedback divider in 24:16. The mask is 0x01FF373F.
- R5: Each clock, wake flag n (offset 0x1C) is set when wake input n is high and wake-control bit n was set. Writing a one to a flag clears it. A set and a clear of the same flag in the same clock leave it set.
- R6: The clk_en_o and rst_o outputs equal the clock-enable and reset-line words at all times.
- R7: Stub s is gated while its clock-enable bit is clear. It then reads 0, and it reads its earlier contents again once the bit is set. Stub 0 uses clock bit 0, stub 1 uses bit 6 and stub 2 uses bit 11.
- R8: Writes to a stub that is gated or held in reset leave its registers unchanged.
- R9: Stub s is held in reset while its reset-line bit is set. The reset bits are 0 for stub 0, 6 for stub 1 and 11 for stub 2. While held, the stub is reloaded with its initial values, so register r reads 0x5A000000 + s*256 + r after release. Stub 0 reads 0xFFFFFFFF while held.
- R10: Stubs 1 and 2 read 0 while held in reset.
- R11: A stub that is both gated and held in reset reads as held in reset.
- R12: A stub select value of NSTUB or above reads 0 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | ADDR_W | Control word byte address |
| csr_we | input | 1 | Control word write strobe |
| csr_wdata | input | 32 | Control word write data |
| csr_rdata | output | 32 | Control word read data (combinational) |
| wake_i | input | WAKE_N | Wake-up request inputs |
| clk_en_o | output | 32 | Per-peripheral clock enables |
| rst_o | output | 32 | Per-peripheral reset holds, high = held |
| clk_sel_o | output | 32 | Clock source selection word |
| clk_div_o | output | 32 | Clock divider word |
| pll0_o | output | 32 | PLL0 configuration word |
| pll1_o | output | 32 | PLL1 configuration word |
| pm_o | output | 32 | Power-management word |
| stub_sel | input | SEL_W | Peripheral stub select |
| stub_addr | input | REG_AW | Register index within a stub |
| stub_we | input | 1 | Stub write strobe |
| stub_wdata | input | 32 | Stub write data |
| stub_rdata | output | 32 | Isolated stub read data (combinational) |

## Verification
The checker watches, on every cycle, the read value of a gated, held or unselected stub, the all-ones read of stub 0 while held, the zero read of unmapped offsets, the reserved reset-line bits and the capture of masked wake inputs into the flags. Only the bench scenarios can show that a stub keeps its contents across a gate, reloads its initial values after reset and drops writes while isolated. The same holds for the interplay of set and clear on one wake flag, and for the masked readback after a write of all ones.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

  localparam int DW = 32;

  typedef enum logic [3:0] {
    W_CLKEN, W_CLKSEL, W_CLKDIV, W_PLL0, W_PLL1,
    W_PM, W_WCTL, W_WFLG, W_RST, W_NONE
  } csr_e;

  localparam logic [DW-1:0] SEL_MASK = 32'h0000_07CF;
  localparam logic [DW-1:0] DIV_MASK = 32'h3F0F_0300;
  localparam logic [DW-1:0] PLL_MASK = 32'h01FF_373F;
  localparam logic [DW-1:0] PM_MASK  = 32'h0000_000F;
  localparam logic [DW-1:0] RST_MASK = 32'hF80D_FFE9;
  localparam logic [DW-1:0] STUB_INIT_BASE = 32'h5A00_0000;

  typedef struct packed {
    logic [DW-1:0] clken;
    logic [DW-1:0] clksel;
    logic [DW-1:0] clkdiv;
    logic [DW-1:0] pll0;
    logic [DW-1:0] pll1;
    logic [DW-1:0] pm;
    logic [DW-1:0] wctl;
    logic [DW-1:0] wflg;
    logic [DW-1:0] rst;
  } csr_t;

  function automatic csr_e decode_word(input logic [15:0] a);
    csr_e r;
    if (a[1:0] != 2'b00) r = W_NONE;
    else begin
      case (a[15:2])
        14'd0:   r = W_CLKEN;
        14'd1:   r = W_CLKSEL;
        14'd2:   r = W_CLKDIV;
        14'd3:   r = W_PLL0;
        14'd4:   r = W_PLL1;
        14'd5:   r = W_PM;
        14'd6:   r = W_WCTL;
        14'd7:   r = W_WFLG;
        14'd8:   r = W_RST;
        default: r = W_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic int stub_clk_bit(input int s);
    case (s)
      0: return 0;
      1: return 6;
      default: return 11;
    endcase
  endfunction

  function automatic int stub_rst_bit(input int s);
    case (s)
      0: return 0;
      1: return 6;
      default: return 11;
    endcase
  endfunction

  function automatic logic stub_held_ones(input int s);
    return (s == 0);
  endfunction

  function automatic logic [DW-1:0] stub_init(input int s, input int r);
    return STUB_INIT_BASE | DW'(s * 256) | DW'(r);
  endfunction

endpackage

// File: rtl/clkrst_csr.sv
module clkrst_csr
  import clkrst_pkg::*;
#(
  parameter int WAKE_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  csr_e              wsel,
  input  logic [DW-1:0]     wdata,
  input  logic [WAKE_N-1:0] wake_i,
  output csr_t              q
);

  localparam logic [DW-1:0] WMASK = DW'((64'd1 << WAKE_N) - 64'd1);

  csr_t          d;
  logic [DW-1:0] wake_hit;
  logic [DW-1:0] wflg_clr;
  logic          upd;

  always_comb begin
    wake_hit = DW'(wake_i) & q.wctl & WMASK;
    wflg_clr = (we && wsel == W_WFLG) ? wdata : '0;
    d        = q;
    if (we) begin
      case (wsel)
        W_CLKEN:  d.clken  = wdata;
        W_CLKSEL: d.clksel = wdata & SEL_MASK;
        W_CLKDIV: d.clkdiv = wdata & DIV_MASK;
        W_PLL0:   d.pll0   = wdata & PLL_MASK;
        W_PLL1:   d.pll1   = wdata & PLL_MASK;
        W_PM:     d.pm     = wdata & PM_MASK;
        W_WCTL:   d.wctl   = wdata & WMASK;
        W_RST:    d.rst    = wdata & RST_MASK;
        default:  ;
      endcase
    end
    d.wflg = (q.wflg & ~wflg_clr) | wake_hit;
    upd    = we | (|wake_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.clken  <= '1;
      q.clksel <= '0;
      q.clkdiv <= '0;
      q.pll0   <= '0;
      q.pll1   <= '0;
      q.pm     <= '0;
      q.wctl   <= '0;
      q.wflg   <= '0;
      q.rst    <= '0;
    end else if (upd) begin
      q <= d;
    end
  end

endmodule

// File: rtl/clkrst_stub.sv
module clkrst_stub
  import clkrst_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              we,
  input  logic [REG_AW-1:0] ridx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);

  localparam int NREG = 1 << REG_AW;

  logic [DW-1:0] r_q [NREG];
  logic [DW-1:0] r_d [NREG];
  logic          r_en [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [DW-1:0] INIT = stub_init(IDX, k);

    always_comb begin
      r_en[k] = hold | (we && ridx == REG_AW'(k));
      r_d[k]  = hold ? INIT : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       r_q[k] <= INIT;
      else if (r_en[k]) r_q[k] <= r_d[k];
    end
  end

  assign rdata = r_q[ridx];

endmodule

// File: rtl/clkrst_rdiso.sv
module clkrst_rdiso
  import clkrst_pkg::*;
#(
  parameter int NSTUB = 3,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0]    sel,
  input  logic [NSTUB-1:0]    gated,
  input  logic [NSTUB-1:0]    held,
  input  logic [DW-1:0]       raw [NSTUB],
  output logic [DW-1:0]       rdata
);

  logic [DW-1:0] iso [NSTUB];

  for (genvar i = 0; i < NSTUB; i++) begin : g_iso
    localparam logic [DW-1:0] HELD_VAL = stub_held_ones(i) ? '1 : '0;
    always_comb begin
      if (held[i])       iso[i] = HELD_VAL;
      else if (gated[i]) iso[i] = '0;
      else               iso[i] = raw[i];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSTUB; i++) begin
      if (sel == SEL_W'(i)) rdata = iso[i];
    end
  end

endmodule

// File: rtl/clkrst_regbank.sv
module clkrst_regbank
  import clkrst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WAKE_N = 8,
  parameter int NSTUB  = 3,
  parameter int SEL_W  = 2,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic [WAKE_N-1:0] wake_i,
  output logic [31:0]       clk_en_o,
  output logic [31:0]       rst_o,
  output logic [31:0]       clk_sel_o,
  output logic [31:0]       clk_div_o,
  output logic [31:0]       pll0_o,
  output logic [31:0]       pll1_o,
  output logic [31:0]       pm_o,
  input  logic [SEL_W-1:0]  stub_sel,
  input  logic [REG_AW-1:0] stub_addr,
  input  logic              stub_we,
  input  logic [31:0]       stub_wdata,
  output logic [31:0]       stub_rdata
);

  csr_e             wsel;
  csr_t             cq;
  logic [NSTUB-1:0] gated;
  logic [NSTUB-1:0] held;
  logic [DW-1:0]    raw [NSTUB];

  assign wsel = decode_word(16'(csr_addr));

  clkrst_csr #(.WAKE_N(WAKE_N)) u_csr (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (csr_we),
    .wsel   (wsel),
    .wdata  (csr_wdata),
    .wake_i (wake_i),
    .q      (cq)
  );

  always_comb begin
    case (wsel)
      W_CLKEN:  csr_rdata = cq.clken;
      W_CLKSEL: csr_rdata = cq.clksel;
      W_CLKDIV: csr_rdata = cq.clkdiv;
      W_PLL0:   csr_rdata = cq.pll0;
      W_PLL1:   csr_rdata = cq.pll1;
      W_PM:     csr_rdata = cq.pm;
      W_WCTL:   csr_rdata = cq.wctl;
      W_WFLG:   csr_rdata = cq.wflg;
      W_RST:    csr_rdata = cq.rst;
      default:  csr_rdata = '0;
    endcase
  end

  assign clk_en_o  = cq.clken;
  assign rst_o     = cq.rst;
  assign clk_sel_o = cq.clksel;
  assign clk_div_o = cq.clkdiv;
  assign pll0_o    = cq.pll0;
  assign pll1_o    = cq.pll1;
  assign pm_o      = cq.pm;

  for (genvar i = 0; i < NSTUB; i++) begin : g_stub
    localparam int CB = stub_clk_bit(i);
    localparam int RB = stub_rst_bit(i);
    logic wr_ok;

    assign gated[i] = ~cq.clken[CB];
    assign held[i]  = cq.rst[RB];
    assign wr_ok    = stub_we && (stub_sel == SEL_W'(i)) && !gated[i] && !held[i];

    clkrst_stub #(.IDX(i), .REG_AW(REG_AW)) u_stub (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (held[i]),
      .we    (wr_ok),
      .ridx  (stub_addr),
      .wdata (stub_wdata),
      .rdata (raw[i])
    );
  end

  clkrst_rdiso #(.NSTUB(NSTUB), .SEL_W(SEL_W)) u_iso (
    .sel   (stub_sel),
    .gated (gated),
    .held  (held),
    .raw   (raw),
    .rdata (stub_rdata)
  );

endmodule

// File: rtl/clkrst_chk.sv
module clkrst_chk
  import clkrst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WAKE_N = 8,
  parameter int NSTUB  = 3,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [31:0]       csr_rdata,
  input logic [31:0]       clk_en_o,
  input logic [31:0]       rst_o,
  input logic [WAKE_N-1:0] wake_i,
  input logic [31:0]       wctl,
  input logic [31:0]       wflg,
  input logic [SEL_W-1:0]  stub_sel,
  input logic [31:0]       stub_rdata
);

  localparam logic [31:0] WMASK = 32'((64'd1 << WAKE_N) - 64'd1);

  int   sidx;
  logic valid_sel;
  logic s_gated;
  logic s_held;
  logic s_ones;

  always_comb begin
    sidx      = int'(stub_sel);
    valid_sel = sidx < NSTUB;
    s_gated   = ~clk_en_o[stub_clk_bit(sidx)];
    s_held    = rst_o[stub_rst_bit(sidx)];
    s_ones    = stub_held_ones(sidx);
  end

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_word(16'(csr_addr)) == W_NONE) |-> (csr_rdata == 32'h0));

  p_rst_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_o & ~RST_MASK) == 32'h0));

  p_wake_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((32'($past(wake_i)) & $past(wctl)) & ~wflg & WMASK) == 32'h0));

  p_gate_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_sel && s_gated && !s_held) |-> (stub_rdata == 32'h0));

  p_held_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_sel && s_held && s_ones) |-> (stub_rdata == 32'hFFFF_FFFF));

  p_held_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_sel && s_held && !s_ones) |-> (stub_rdata == 32'h0));

  p_bad_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_sel) |-> (stub_rdata == 32'h0));

endmodule

bind clkrst_regbank clkrst_chk #(
  .ADDR_W(ADDR_W), .WAKE_N(WAKE_N), .NSTUB(NSTUB), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_addr   (csr_addr),
  .csr_rdata  (csr_rdata),
  .clk_en_o   (clk_en_o),
  .rst_o      (rst_o),
  .wake_i     (wake_i),
  .wctl       (cq.wctl),
  .wflg       (cq.wflg),
  .stub_sel   (stub_sel),
  .stub_rdata (stub_rdata)
);

// File: tb/sim_clkrst_regbank.sv
module sim_clkrst_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [7:0]  wake_i = '0;
  logic [31:0] clk_en_o, rst_o, clk_sel_o, clk_div_o, pll0_o, pll1_o, pm_o;
  logic [1:0]  stub_sel = '0;
  logic [1:0]  stub_addr = '0;
  logic        stub_we = 1'b0;
  logic [31:0] stub_wdata = '0;
  logic [31:0] stub_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkrst_regbank u0 (
    .clk(clk), .rst_n(rst_n),
    .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .wake_i(wake_i), .clk_en_o(clk_en_o), .rst_o(rst_o), .clk_sel_o(clk_sel_o),
    .clk_div_o(clk_div_o), .pll0_o(pll0_o), .pll1_o(pll1_o), .pm_o(pm_o),
    .stub_sel(stub_sel), .stub_addr(stub_addr), .stub_we(stub_we),
    .stub_wdata(stub_wdata), .stub_rdata(stub_rdata)
  );

  // Reference model, kept behaviourally
  logic [31:0] m_w [9];
  logic [31:0] m_s [3][4];
  int cbit [3] = '{0, 6, 11};

  function automatic logic [31:0] init_of(int s, int r);
    return 32'h5A00_0000 + 32'(s * 256 + r);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 9; k++) m_w[k] = 32'h0;
    m_w[0] = 32'hFFFF_FFFF;
    for (int s = 0; s < 3; s++)
      for (int r = 0; r < 4; r++) m_s[s][r] = init_of(s, r);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      logic [31:0] oen, orst, octl, clr;
      oen = m_w[0]; orst = m_w[8]; octl = m_w[6];
      for (int s = 0; s < 3; s++) begin
        if (orst[cbit[s]])
          for (int r = 0; r < 4; r++) m_s[s][r] = init_of(s, r);
        else if (stub_we && int'(stub_sel) == s && oen[cbit[s]])
          m_s[s][stub_addr] = stub_wdata;
      end
      clr = (csr_we && csr_addr == 8'h1C) ? csr_wdata : 32'h0;
      m_w[7] = (m_w[7] & ~clr) | ({24'h0, wake_i} & octl);
      if (csr_we) begin
        case (csr_addr)
          8'h00: m_w[0] = csr_wdata;
          8'h04: m_w[1] = csr_wdata & 32'h0000_07CF;
          8'h08: m_w[2] = csr_wdata & 32'h3F0F_0300;
          8'h0C: m_w[3] = csr_wdata & 32'h01FF_373F;
          8'h10: m_w[4] = csr_wdata & 32'h01FF_373F;
          8'h14: m_w[5] = csr_wdata & 32'h0000_000F;
          8'h18: m_w[6] = csr_wdata & 32'h0000_00FF;
          8'h20: m_w[8] = csr_wdata & 32'hF80D_FFE9;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_csr(logic [7:0] a);
    if (a[1:0] != 0 || a > 8'h20) return 32'h0;
    return m_w[a[7:2]];
  endfunction

  function automatic string tag_csr(logic [7:0] a);
    if (a[1:0] != 0 || a > 8'h20) return "R3";
    if (a == 8'h0C || a == 8'h10) return "R4";
    if (a == 8'h1C) return "R5";
    return "R2";
  endfunction

  function automatic logic [31:0] exp_stub(int s, int r);
    if (s > 2) return 32'h0;
    if (m_w[8][cbit[s]]) return (s == 0) ? 32'hFFFF_FFFF : 32'h0;
    if (!m_w[0][cbit[s]]) return 32'h0;
    return m_s[s][r];
  endfunction

  function automatic string tag_stub(int s);
    if (s > 2) return "R12";
    if (m_w[8][cbit[s]]) return (s == 0) ? "R9" : "R10";
    if (!m_w[0][cbit[s]]) return "R7";
    return "R8";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6", clk_en_o, m_w[0]);
      chk("R6", rst_o, m_w[8]);
      chk(tag_csr(csr_addr), csr_rdata, exp_csr(csr_addr));
      chk(tag_stub(int'(stub_sel)), stub_rdata, exp_stub(int'(stub_sel), int'(stub_addr)));
    end
  end

  task automatic wr_csr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    csr_addr = a; csr_we = 1'b1; csr_wdata = d;
    @(posedge clk); #2;
    csr_we = 1'b0;
  endtask

  task automatic rd_csr(logic [7:0] a, logic [31:0] e, string tag);
    @(posedge clk); #2;
    csr_addr = a;
    @(negedge clk);
    chk(tag, csr_rdata, e);
  endtask

  task automatic wr_stub(int s, int r, logic [31:0] d);
    @(posedge clk); #2;
    stub_sel = 2'(s); stub_addr = 2'(r); stub_wdata = d; stub_we = 1'b1;
    @(posedge clk); #2;
    stub_we = 1'b0;
  endtask

  task automatic rd_stub(int s, int r, logic [31:0] e, string tag);
    @(posedge clk); #2;
    stub_sel = 2'(s); stub_addr = 2'(r);
    @(negedge clk);
    chk(tag, stub_rdata, e);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset values
    rd_csr(8'h00, 32'hFFFF_FFFF, "R1");
    rd_csr(8'h04, 32'h0, "R1");
    rd_csr(8'h20, 32'h0, "R1");
    rd_stub(1, 3, init_of(1, 3), "R1");

    // R2 / R4: masked write of all ones
    for (int k = 0; k < 9; k++) wr_csr(8'(k * 4), 32'hFFFF_FFFF);
    rd_csr(8'h04, 32'h0000_07CF, "R2");
    rd_csr(8'h08, 32'h3F0F_0300, "R2");
    rd_csr(8'h14, 32'h0000_000F, "R2");
    rd_csr(8'h18, 32'h0000_00FF, "R2");
    rd_csr(8'h20, 32'hF80D_FFE9, "R2");
    rd_csr(8'h0C, 32'h01FF_373F, "R4");
    rd_csr(8'h10, 32'h01FF_373F, "R4");
    wr_csr(8'h0C, 32'h0012_1105);
    rd_csr(8'h0C, 32'h0012_1105, "R4");

    // R3: unmapped and misaligned
    wr_csr(8'h24, 32'h1234_5678);
    rd_csr(8'h24, 32'h0, "R3");
    wr_csr(8'h05, 32'h0);
    rd_csr(8'h05, 32'h0, "R3");
    rd_csr(8'h04, 32'h0000_07CF, "R3");
    rd_csr(8'h40, 32'h0, "R3");

    // R5: wake flags
    wr_csr(8'h18, 32'h05);
    @(posedge clk); #2 wake_i = 8'hFF;
    @(posedge clk); #2 wake_i = 8'h00;
    rd_csr(8'h1C, 32'h05, "R5");
    wr_csr(8'h1C, 32'h01);
    rd_csr(8'h1C, 32'h04, "R5");
    @(posedge clk); #2;
    csr_addr = 8'h1C; csr_we = 1'b1; csr_wdata = 32'h04; wake_i = 8'h04;
    @(posedge clk); #2;
    csr_we = 1'b0; wake_i = 8'h00;
    rd_csr(8'h1C, 32'h04, "R5");
    wr_csr(8'h1C, 32'h04);
    rd_csr(8'h1C, 32'h0, "R5");

    // Release stubs (all were held by the all-ones write)
    wr_csr(8'h20, 32'h0);
    rd_stub(0, 1, init_of(0, 1), "R9");

    // R7 / R8: gating
    wr_stub(0, 1, 32'h0000_1234);
    rd_stub(0, 1, 32'h0000_1234, "R8");
    wr_csr(8'h00, 32'hFFFF_FFFE);
    rd_stub(0, 1, 32'h0, "R7");
    wr_stub(0, 1, 32'h0000_9999);
    wr_csr(8'h00, 32'hFFFF_FFFF);
    rd_stub(0, 1, 32'h0000_1234, "R7");
    rd_stub(2, 0, init_of(2, 0), "R7");

    // R9: flash-type reset
    wr_csr(8'h20, 32'h0000_0001);
    rd_stub(0, 1, 32'hFFFF_FFFF, "R9");
    wr_csr(8'h20, 32'h0);
    rd_stub(0, 1, init_of(0, 1), "R9");

    // R10 / R8: Ethernet-type reset, write while held
    wr_stub(1, 2, 32'h0000_ABCD);
    rd_stub(1, 2, 32'h0000_ABCD, "R8");
    wr_csr(8'h20, 32'h0000_0040);
    rd_stub(1, 2, 32'h0, "R10");
    wr_stub(1, 2, 32'h0000_5555);
    wr_csr(8'h20, 32'h0);
    rd_stub(1, 2, init_of(1, 2), "R10");

    // R11: gated and held
    wr_csr(8'h00, 32'hFFFF_FFFE);
    wr_csr(8'h20, 32'h0000_0001);
    rd_stub(0, 0, 32'hFFFF_FFFF, "R11");
    wr_csr(8'h20, 32'h0000_0800);
    rd_stub(2, 3, 32'h0, "R10");
    wr_csr(8'h20, 32'h0);
    wr_csr(8'h00, 32'hFFFF_FFFF);

    // R12: unused select
    wr_stub(3, 0, 32'hDEAD_BEEF);
    rd_stub(3, 0, 32'h0, "R12");
    rd_stub(0, 0, init_of(0, 0), "R12");

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule